// File: doc/BRIEF.md
# Decimating Sample Averaging Accumulator

This block sits between the raw result stream of a converter and the result FIFO that follows it. When averaging is on, it sums a fixed power-of-two number of consecutive accepted samples and then emits one word: the floor of their mean. The output rate is therefore the input rate divided by the group size. When averaging is off, every sample is forwarded unchanged, one cycle later. Averaging is off after reset.

A single instance serves every channel. The same ratio applies to every sample, whichever channel tag it carries and whether that channel is single-ended or differential. The emitted word carries the tag of the sample that closed its group. If the effective ratio changes, the partial group is dropped, so a partial group is never emitted. A busy flag shows that a partial group is held. Control logic can wait for that flag to clear before it stops the clock.

Top module: `sample_decimator`

## Requirements
- R1: During and right after reset, `out_valid` and `busy` are 0.
- R2: When `avg_en` is 0 or `ratio_code` is 0 (bypass), each cycle with `in_valid`=1 gives `out_valid`=1 in the next cycle, with `out_sample` and `out_tag` equal to that input. `busy` stays 0.
- R3: With `avg_en`=1, `ratio_code` value k in 1..6 selects a group size of 2^k samples. Code 7 is treated as 6, giving 64 samples.
- R4: In averaging mode, exactly one output is produced per group. It appears in the cycle after the last accepted sample of the group.
- R5: The output value is the sum of the group's samples shifted right by k, which is the floor of the mean.
- R6: An averaged output carries the tag of the last sample of its group.
- R7: `out_valid` is high only in the cycle after an accepted input that either completes a group or passes in bypass.
- R8: A change of the effective ratio (k, or bypass versus averaging) drops the partial group. A sample accepted in the cycle of the change becomes the first sample of a new group.
- R9: `busy` is 1 exactly while a partial group (1 to N-1 samples) is held, evaluated one cycle after the input that changed it.
- R10: A group of 64 full-scale samples averages to full scale without overflow.
- R11: Cycles with `in_valid`=0 do not advance or disturb the current group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | SAMPLE_W | Raw conversion result |
| in_tag | input | TAG_W | Channel tag of the input sample |
| avg_en | input | 1 | Averaging enable |
| ratio_code | input | RATIO_W | Group size code: k selects 2^k samples |
| out_valid | output | 1 | One-cycle result qualifier |
| out_sample | output | SAMPLE_W | Averaged or bypassed result |
| out_tag | output | TAG_W | Channel tag of the result |
| busy | output | 1 | A partial group is held |

## Verification
Every result is due exactly one clock after the input that produces it. In bypass, that input is the sample itself. In averaging mode, it is the sample that closes the group. `busy` reflects the group state one clock after each accepted sample or ratio change. The bench changes its inputs on the falling edge and advances a reference model for that cycle. After the next rising edge has registered the result, it compares `out_valid`, the data, the tag and `busy` on the following falling edge. Per-ratio output counts are compared at the end of each phase, which confirms the decimation factor.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

    // Reduce a raw ratio code to a shift amount, saturating at max_log2.
    function automatic int unsigned clamp_shift(input int unsigned code,
                                                input int unsigned max_log2);
        return (code > max_log2) ? max_log2 : code;
    endfunction

endpackage

// File: rtl/sdec_ratio_decode.sv
module sdec_ratio_decode #(
    parameter int RATIO_W  = 3,
    parameter int MAX_LOG2 = 6,
    localparam int SHIFT_W = $clog2(MAX_LOG2 + 1)
) (
    input  logic               avg_en,
    input  logic [RATIO_W-1:0] ratio_code,
    output logic [SHIFT_W-1:0] shift,
    output logic               active
);
    import sdec_pkg::*;

    always_comb begin
        active = avg_en && (ratio_code != '0);
        shift  = active ? SHIFT_W'(clamp_shift(int'(ratio_code), MAX_LOG2)) : '0;
    end

endmodule

// File: rtl/sdec_accum.sv
module sdec_accum #(
    parameter int SAMPLE_W = 12,
    parameter int MAX_LOG2 = 6,
    localparam int SHIFT_W = $clog2(MAX_LOG2 + 1),
    localparam int ACC_W   = SAMPLE_W + MAX_LOG2,
    localparam int CNT_W   = MAX_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SHIFT_W-1:0]  shift,
    input  logic                active,
    output logic                grp_done,
    output logic [ACC_W-1:0]    grp_sum,
    output logic                busy
);
    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [CNT_W-1:0]   cnt;
        logic [SHIFT_W-1:0] shift;
        logic               active;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic             cfg_chg;
    logic [ACC_W-1:0] base_acc;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W:0]   span_d;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        cfg_chg  = (shift != st_q.shift) || (active != st_q.active);
        base_acc = cfg_chg ? '0 : st_q.acc;
        base_cnt = cfg_chg ? '0 : st_q.cnt;
        span_d   = (CNT_W+1)'(1) << shift;
        last_idx = CNT_W'(span_d - (CNT_W+1)'(1));
        grp_sum  = base_acc + ACC_W'(in_sample);
        grp_done = in_valid && active && (base_cnt == last_idx);

        st_d        = st_q;
        st_d.shift  = shift;
        st_d.active = active;
        st_d.acc    = base_acc;
        st_d.cnt    = base_cnt;
        if (!active) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (in_valid) begin
            if (grp_done) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = grp_sum;
                st_d.cnt = base_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

    // Held count stays below the group size of the held configuration.
    logic [CNT_W:0] span_q;
    assign span_q = (CNT_W+1)'(1) << st_q.shift;

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W+1)'(st_q.cnt) < span_q)
        else $error("group count exceeds group size");

    p_busy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> !busy)
        else $error("busy still set after group completion");

    p_bypass_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !busy)
        else $error("busy set in bypass");

endmodule

// File: rtl/sdec_out_stage.sv
module sdec_out_stage #(
    parameter int SAMPLE_W = 12,
    parameter int TAG_W    = 4,
    parameter int MAX_LOG2 = 6,
    localparam int SHIFT_W = $clog2(MAX_LOG2 + 1),
    localparam int ACC_W   = SAMPLE_W + MAX_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pass_fire,
    input  logic                grp_done,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic [ACC_W-1:0]    grp_sum,
    input  logic [SHIFT_W-1:0]  shift,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [TAG_W-1:0]    out_tag
);
    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] data;
        logic [TAG_W-1:0]    tag;
    } out_state_t;

    out_state_t st_d, st_q;
    logic [ACC_W-1:0] shifted [MAX_LOG2+1];
    logic [ACC_W-1:0] picked;

    genvar k;
    generate
        for (k = 0; k <= MAX_LOG2; k++) begin : g_shift
            assign shifted[k] = grp_sum >> k;
        end
    endgenerate

    always_comb begin
        picked = shifted[0];
        for (int i = 1; i <= MAX_LOG2; i++) begin
            if (int'(shift) == i) picked = shifted[i];
        end

        st_d       = st_q;
        st_d.valid = pass_fire || grp_done;
        if (pass_fire) begin
            st_d.data = in_sample;
            st_d.tag  = in_tag;
        end else if (grp_done) begin
            st_d.data = picked[SAMPLE_W-1:0];
            st_d.tag  = in_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_sample = st_q.data;
    assign out_tag    = st_q.tag;

    // The mean of a group never needs more than SAMPLE_W bits.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |-> (picked >> SAMPLE_W) == '0)
        else $error("averaged value exceeds sample width");

    p_single_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_fire && grp_done))
        else $error("bypass and group completion in same cycle");

endmodule

// File: rtl/sample_decimator.sv
module sample_decimator #(
    parameter int SAMPLE_W = 12,
    parameter int TAG_W    = 4,
    parameter int RATIO_W  = 3,
    parameter int MAX_LOG2 = 6,
    localparam int SHIFT_W = $clog2(MAX_LOG2 + 1),
    localparam int ACC_W   = SAMPLE_W + MAX_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic                avg_en,
    input  logic [RATIO_W-1:0]  ratio_code,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [TAG_W-1:0]    out_tag,
    output logic                busy
);
    logic [SHIFT_W-1:0] shift;
    logic               active;
    logic               grp_done;
    logic [ACC_W-1:0]   grp_sum;
    logic               pass_fire;

    sdec_ratio_decode #(.RATIO_W(RATIO_W), .MAX_LOG2(MAX_LOG2)) u_decode (
        .avg_en     (avg_en),
        .ratio_code (ratio_code),
        .shift      (shift),
        .active     (active)
    );

    sdec_accum #(.SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .shift     (shift),
        .active    (active),
        .grp_done  (grp_done),
        .grp_sum   (grp_sum),
        .busy      (busy)
    );

    assign pass_fire = in_valid && !active;

    sdec_out_stage #(.SAMPLE_W(SAMPLE_W), .TAG_W(TAG_W), .MAX_LOG2(MAX_LOG2)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass_fire  (pass_fire),
        .grp_done   (grp_done),
        .in_sample  (in_sample),
        .in_tag     (in_tag),
        .grp_sum    (grp_sum),
        .shift      (shift),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_tag    (out_tag)
    );

    p_out_follows_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid))
        else $error("output without a preceding input");

    p_bypass_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !active) |=> (out_valid && out_sample == $past(in_sample)))
        else $error("bypass did not forward sample");

    p_tag_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == $past(in_tag))
        else $error("output tag is not that of the last sample");

endmodule

// File: tb/sample_decimator_test.sv
module sample_decimator_test;
    localparam int SW = 12;
    localparam int TW = 4;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [TW-1:0] in_tag = '0;
    logic          avg_en = 1'b0;
    logic [RW-1:0] ratio_code = '0;
    logic          out_valid;
    logic [SW-1:0] out_sample;
    logic [TW-1:0] out_tag;
    logic          busy;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    int m_shift_prev = 0;
    longint m_acc = 0;
    int m_cnt = 0;
    int out_seen = 0;

    always #10 clk = ~clk;

    sample_decimator #(.SAMPLE_W(SW), .TAG_W(TW), .RATIO_W(RW), .MAX_LOG2(6)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_tag(in_tag), .avg_en(avg_en), .ratio_code(ratio_code),
        .out_valid(out_valid), .out_sample(out_sample), .out_tag(out_tag),
        .busy(busy)
    );

    function automatic int eff_shift(input logic en, input int code);
        if (!en || code == 0) return 0;
        return (code > 6) ? 6 : code;
    endfunction

    task automatic check(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, let the edge register, check at next negedge.
    task automatic step(input logic v, input int s, input int t);
        int sh;
        logic ev;
        int es;
        in_valid  = v;
        in_sample = SW'(s);
        in_tag    = TW'(t);
        sh = eff_shift(avg_en, int'(ratio_code));
        if (sh != m_shift_prev) begin
            m_acc = 0;
            m_cnt = 0;
        end
        m_shift_prev = sh;
        ev = 1'b0;
        es = 0;
        if (v) begin
            if (sh == 0) begin
                ev = 1'b1;
                es = s;
            end else begin
                m_acc += s;
                m_cnt++;
                if (m_cnt == (1 << sh)) begin
                    ev = 1'b1;
                    es = int'(m_acc >> sh);
                    m_acc = 0;
                    m_cnt = 0;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(cur_req, longint'(out_valid), longint'(ev), "out_valid");
        if (ev && out_valid) begin
            out_seen++;
            check(cur_req, longint'(out_sample), longint'(es), "out_sample");
            check("R6", longint'(out_tag), longint'(t), "out_tag");
        end
        check("R9", longint'(busy), longint'(m_cnt != 0), "busy");
    endtask

    task automatic run_ratio(input int code, input int groups);
        int n;
        int fed;
        avg_en = 1'b1;
        ratio_code = RW'(code);
        n = 1 << eff_shift(1'b1, code);
        out_seen = 0;
        fed = 0;
        while (fed < n * groups) begin
            if (($urandom % 4) == 0) begin
                step(1'b0, 0, 0);              // R11: idle cycle inside a group
            end else begin
                step(1'b1, int'($urandom % 4096), int'($urandom % 16));
                fed++;
            end
        end
        check("R4", out_seen, groups, $sformatf("outputs at code %0d", code));
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", longint'(out_valid), 0, "out_valid in reset");
        check("R1", longint'(busy), 0, "busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", longint'(out_valid), 0, "out_valid after reset");
        check("R1", longint'(busy), 0, "busy after reset");

        // R2: bypass via enable low, then via code 0
        cur_req = "R2";
        avg_en = 1'b0;
        ratio_code = 3'd3;
        for (int i = 0; i < 20; i++) step(1'b1, int'($urandom % 4096), int'($urandom % 16));
        avg_en = 1'b1;
        ratio_code = 3'd0;
        for (int i = 0; i < 20; i++) step(($urandom % 3) != 0, int'($urandom % 4096), int'($urandom % 16));

        // R3 R4 R5 R6: every ratio, code 7 saturates to 64
        cur_req = "R5";
        for (int c = 1; c <= 6; c++) run_ratio(c, 3);
        cur_req = "R3";
        run_ratio(7, 2);

        // R10: full-scale group of 64
        cur_req = "R10";
        avg_en = 1'b1;
        ratio_code = 3'd6;
        for (int i = 0; i < 64; i++) step(1'b1, 4095, 9);
        check("R10", longint'(out_sample), 4095, "full-scale mean");

        // R8: ratio change mid-group drops the partial sum
        cur_req = "R8";
        ratio_code = 3'd3;
        for (int i = 0; i < 5; i++) step(1'b1, 4000, 1);
        ratio_code = 3'd2;
        out_seen = 0;
        step(1'b1, 100, 2);
        step(1'b1, 200, 2);
        step(1'b1, 300, 2);
        step(1'b1, 400, 3);
        check("R8", out_seen, 1, "outputs after ratio change");
        check("R8", longint'(out_sample), 250, "mean of new group only");
        // R8: enable drop clears a partial group, busy falls
        for (int i = 0; i < 3; i++) step(1'b1, 50, 4);
        avg_en = 1'b0;
        step(1'b0, 0, 0);
        check("R8", longint'(busy), 0, "busy after enable drop");
        avg_en = 1'b1;
        out_seen = 0;
        for (int i = 0; i < 4; i++) step(1'b1, 8, 5);
        check("R8", out_seen, 1, "fresh group after re-enable");
        check("R8", longint'(out_sample), 8, "no stale partial sum");

        // mixed random configuration changes
        cur_req = "R7";
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 40) == 0) ratio_code = RW'($urandom % 8);
            if (($urandom % 60) == 0) avg_en = ~avg_en;
            step(($urandom % 3) != 0, int'($urandom % 4096), int'($urandom % 16));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule